// File: doc/BRIEF.md
# CPU External Interrupt Level Arbiter

This block sits next to a processor core. It receives interrupt level lines numbered 0 to 15 and keeps a register of which lines are currently held. From that register it decides which external trap the core should see. Lines change through single assert or deassert events naming one line, or through a load of the whole level vector at once. After every such change the block arbitrates again over all held lines, not just the line that changed. The winner is the highest held level from 15 down to 1. It is encoded as the external-interrupt trap type with the level in the low four bits.

The block owns the pending trap index and a level-sensitive hard-interrupt request to the core. It writes a new external index only when nothing is pending or when the pending index is itself external. The request rises when the written index differs from the one already pending. When every line has been released and the pending index is external, the block clears the index and drops the request. The core's exception logic can write the pending index directly. A non-external index written this way is never replaced or cleared by line activity. Any raise of a line also sends a one-cycle wake pulse that clears a halted core.

Top module: `ext_irq_level_arb`

## Requirements
- R1: An assert event for line N sets N in the held set and a deassert event clears it; with N the highest held level, the index becomes EXT_TYPE|N one cycle later.
- R2: Every line event re-arbitrates over all held lines, so dropping the highest held line moves the index to the next highest held level.
- R3: `wake` is high for exactly the cycle after an assert event, or after a vector load that adds at least one line not already held; a deassert event never produces it.
- R4: The highest held level wins; level 0 alone is never selected, and it leaves the index and request unchanged.
- R5: An external index equals EXT_TYPE (low four bits zero, default 0x10) ORed with the selected level in bits [3:0]; an index is external when its bits above bit 3 equal EXT_TYPE.
- R6: While the index is non-zero and not external, line events neither replace nor clear it.
- R7: `hard_req` rises in the cycle the index takes a new external value; an arbitration result equal to the pending index leaves index and request unchanged.
- R8: When an event leaves no line held and the pending index is external, the index becomes 0 and `hard_req` falls.
- R9: A vector load replaces the whole held set with `vec_in` and takes priority over a line event in the same cycle.
- R10: An exception write (`exc_set`) loads `exc_idx` into the index the next cycle, wins over arbitration in that cycle, and leaves `hard_req` unchanged.
- R11: After reset the index is 0, and `hard_req` and `wake` are low.
- R12: Every update appears on the clock edge that samples the input change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_vld | input | 1 | A single-line event this cycle |
| evt_up | input | 1 | 1 = assert the line, 0 = deassert it |
| evt_line | input | 4 | Line number of the event |
| vec_load | input | 1 | Replace the held set with `vec_in` |
| vec_in | input | 16 | Level vector for a load |
| exc_set | input | 1 | Core writes the pending index |
| exc_idx | input | 8 | Index written by the core |
| trap_idx | output | 8 | Pending trap index |
| hard_req | output | 1 | Hard-interrupt request to the core |
| wake | output | 1 | One-cycle pulse that clears a halted state |

## Verification
The bench runs rising sequences (5 then 9 then 3) and falling sequences. Together these separate re-arbitration over every held line from a compare against only the newly raised line. Lowering the top line has to land on the next held level, and the index must not go straight to zero. A lone level-0 line, and a vector load that coincides with an event, expose encoder and priority faults. A non-external index written by the core and then hit by raises and releases shows whether line activity respects it. A long random stretch of mixed events, loads and core writes is compared each cycle against a behavioural model.

// File: rtl/eil_arb_pkg.sv
package eil_arb_pkg;
  localparam int unsigned LEVELS = 16;
  localparam int unsigned LVL_W  = $clog2(LEVELS);
  localparam int unsigned IDX_W  = 8;

  typedef logic [LEVELS-1:0] lines_t;
  typedef logic [IDX_W-1:0]  tidx_t;
  typedef logic [LVL_W-1:0]  lvl_t;

  // An index is external when its bits above the level field match the type.
  function automatic logic idx_is_ext(tidx_t idx, tidx_t ext_type);
    return (idx & ~tidx_t'(LEVELS - 1)) == ext_type;
  endfunction

  function automatic tidx_t ext_idx(tidx_t ext_type, lvl_t lvl);
    return ext_type | tidx_t'(lvl);
  endfunction

  function automatic lines_t line_bit(lvl_t line);
    return lines_t'(1) << line;
  endfunction
endpackage

// File: rtl/eil_line_tracker.sv
module eil_line_tracker
  import eil_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   evt_vld,
  input  logic   evt_up,
  input  lvl_t   evt_line,
  input  logic   vec_load,
  input  lines_t vec_in,
  output lines_t lines_nxt,
  output lines_t lines_q,
  output logic   trig,
  output logic   wake_q
);
  logic wake_evt;

  always_comb begin
    lines_nxt = lines_q;
    wake_evt  = 1'b0;
    if (vec_load) begin
      lines_nxt = vec_in;
      wake_evt  = |(vec_in & ~lines_q);
    end else if (evt_vld) begin
      if (evt_up) begin
        lines_nxt = lines_q | line_bit(evt_line);
        wake_evt  = 1'b1;
      end else begin
        lines_nxt = lines_q & ~line_bit(evt_line);
      end
    end
  end

  assign trig = vec_load | evt_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lines_q <= '0;
      wake_q  <= 1'b0;
    end else begin
      lines_q <= lines_nxt;
      wake_q  <= wake_evt;
    end
  end

  p_raise_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && evt_up && !vec_load) |=> lines_q[$past(evt_line)]);
  p_lower_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && !evt_up && !vec_load) |=> !lines_q[$past(evt_line)]);
  p_no_wake_on_lower_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && !evt_up && !vec_load) |=> !wake_q);
  p_load_replaces_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |=> lines_q == $past(vec_in));
endmodule

// File: rtl/eil_level_pick.sv
module eil_level_pick
  import eil_arb_pkg::*;
(
  input  lines_t lines,
  output lvl_t   sel_lvl,
  output logic   sel_vld
);
  lines_t above;
  lines_t grant;

  assign above[LEVELS-1] = 1'b0;
  assign grant[0]        = 1'b0;

  genvar gi;
  generate
    for (gi = LEVELS - 2; gi >= 0; gi--) begin : g_above
      assign above[gi] = above[gi+1] | lines[gi+1];
    end
    for (gi = 1; gi < LEVELS; gi++) begin : g_grant
      assign grant[gi] = lines[gi] & ~above[gi];
    end
  endgenerate

  always_comb begin
    sel_lvl = '0;
    for (int i = 1; i < LEVELS; i++) begin
      if (grant[i]) sel_lvl = sel_lvl | lvl_t'(i);
    end
  end

  assign sel_vld = |grant;
endmodule

// File: rtl/eil_trap_index.sv
module eil_trap_index
  import eil_arb_pkg::*;
#(
  parameter tidx_t EXT_TYPE = 8'h10
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   trig,
  input  lines_t lines_nxt,
  input  logic   sel_vld,
  input  lvl_t   sel_lvl,
  input  logic   exc_set,
  input  tidx_t  exc_idx,
  output tidx_t  idx_q,
  output logic   req_q
);
  tidx_t idx_d;
  tidx_t cand;
  logic  req_d;
  logic  cur_ext;
  logic  may_take;
  logic  take;
  logic  drop;

  assign cur_ext  = idx_is_ext(idx_q, EXT_TYPE);
  assign may_take = (idx_q == '0) || cur_ext;
  assign cand     = ext_idx(EXT_TYPE, sel_lvl);
  assign take     = trig && sel_vld && may_take && (cand != idx_q);
  assign drop     = trig && (lines_nxt == '0) && cur_ext;

  always_comb begin
    idx_d = idx_q;
    req_d = req_q;
    if (exc_set) begin
      idx_d = exc_idx;
    end else if (take) begin
      idx_d = cand;
      req_d = 1'b1;
    end else if (drop) begin
      idx_d = '0;
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      req_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      req_q <= req_d;
    end
  end

  p_nonext_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_set && idx_q != '0 && !cur_ext) |=> idx_q == $past(idx_q));
  p_req_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> idx_q != $past(idx_q));
  p_release_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && lines_nxt == '0 && cur_ext && !exc_set) |=> (idx_q == '0 && !req_q));
  p_core_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_set |=> (idx_q == $past(exc_idx) && req_q == $past(req_q)));
endmodule

// File: rtl/ext_irq_level_arb.sv
module ext_irq_level_arb
  import eil_arb_pkg::*;
#(
  parameter logic [IDX_W-1:0] EXT_TYPE = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_vld,
  input  logic              evt_up,
  input  logic [LVL_W-1:0]  evt_line,
  input  logic              vec_load,
  input  logic [LEVELS-1:0] vec_in,
  input  logic              exc_set,
  input  logic [IDX_W-1:0]  exc_idx,
  output logic [IDX_W-1:0]  trap_idx,
  output logic              hard_req,
  output logic              wake
);
  lines_t lines_nxt;
  lines_t lines_q;
  logic   trig;
  lvl_t   sel_lvl;
  logic   sel_vld;

  eil_line_tracker u_track (
    .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .evt_up(evt_up),
    .evt_line(evt_line), .vec_load(vec_load), .vec_in(vec_in),
    .lines_nxt(lines_nxt), .lines_q(lines_q), .trig(trig), .wake_q(wake)
  );

  eil_level_pick u_pick (
    .lines(lines_nxt), .sel_lvl(sel_lvl), .sel_vld(sel_vld)
  );

  eil_trap_index #(.EXT_TYPE(EXT_TYPE)) u_idx (
    .clk(clk), .rst_n(rst_n), .trig(trig), .lines_nxt(lines_nxt),
    .sel_vld(sel_vld), .sel_lvl(sel_lvl), .exc_set(exc_set),
    .exc_idx(exc_idx), .idx_q(trap_idx), .req_q(hard_req)
  );

  p_highest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !exc_set && lines_q[0] && lines_q[LEVELS-1:1] == '0
     && $stable(lines_q)) |-> $stable(trap_idx));
  p_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hard_req) |-> (idx_is_ext(trap_idx, EXT_TYPE) && trap_idx[LVL_W-1:0] != '0));
endmodule

// File: tb/ext_irq_level_arb_tb_top.sv
module ext_irq_level_arb_tb_top;
  localparam int PERIOD = 10;
  localparam int EXT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_vld = 1'b0, evt_up = 1'b0, vec_load = 1'b0, exc_set = 1'b0;
  logic [3:0] evt_line = '0;
  logic [15:0] vec_in = '0;
  logic [7:0] exc_idx = '0;
  logic [7:0] trap_idx;
  logic hard_req, wake;

  int checks = 0;
  int errors = 0;

  bit [15:0] m_lines;
  int m_idx;
  bit m_req, m_wake;

  always #(PERIOD/2) clk = ~clk;

  ext_irq_level_arb dut_i (
    .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .evt_up(evt_up),
    .evt_line(evt_line), .vec_load(vec_load), .vec_in(vec_in),
    .exc_set(exc_set), .exc_idx(exc_idx), .trap_idx(trap_idx),
    .hard_req(hard_req), .wake(wake)
  );

  task automatic expect_eq(int got, int exp, string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic bit model_is_ext(int idx);
    return (idx / 16) * 16 == EXT;
  endfunction

  task automatic model_step();
    bit [15:0] nl;
    bit ev;
    int top;
    ev = vec_load || evt_vld;
    nl = m_lines;
    m_wake = 1'b0;
    if (vec_load) begin
      for (int b = 0; b < 16; b++) if (vec_in[b] && !m_lines[b]) m_wake = 1'b1;
      nl = vec_in;
    end else if (evt_vld) begin
      nl[evt_line] = evt_up;
      m_wake = evt_up;
    end
    top = 0;
    for (int l = 15; l > 0; l--) if (nl[l]) begin top = l; break; end
    if (exc_set) m_idx = int'(exc_idx);
    else if (ev) begin
      if (top > 0 && (m_idx == 0 || model_is_ext(m_idx))) begin
        if (EXT + top != m_idx) begin m_idx = EXT + top; m_req = 1'b1; end
      end else if (nl == 0 && model_is_ext(m_idx)) begin
        m_idx = 0; m_req = 1'b0;
      end
    end
    m_lines = nl;
  endtask

  // R12: outputs compared to the model on every cycle
  task automatic cyc();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    expect_eq(int'(trap_idx), m_idx, "R12 idx");
    expect_eq(int'(hard_req), int'(m_req), "R12 req");
    expect_eq(int'(wake), int'(m_wake), "R12 wake");
  endtask

  task automatic clr();
    evt_vld = 0; vec_load = 0; exc_set = 0;
  endtask
  task automatic ev(bit up, int n);
    evt_vld = 1; evt_up = up; evt_line = 4'(n); cyc(); clr();
  endtask
  task automatic vload(int v);
    vec_load = 1; vec_in = 16'(v); cyc(); clr();
  endtask
  task automatic cwrite(int v);
    exc_set = 1; exc_idx = 8'(v); cyc(); clr();
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_lines = 0; m_idx = 0; m_req = 0; m_wake = 0;
    @(negedge clk); @(negedge clk);
    // R11 reset state
    expect_eq(int'(trap_idx), 0, "R11 idx"); expect_eq(int'(hard_req), 0, "R11 req");
    expect_eq(int'(wake), 0, "R11 wake");
    rst_n = 1'b1;
    cyc();
    // R1 R3 R5 raise 5
    ev(1, 5);
    expect_eq(int'(trap_idx), 'h15, "R1 R5 raise5"); expect_eq(int'(hard_req), 1, "R7 req up");
    expect_eq(int'(wake), 1, "R3 wake on raise");
    cyc(); expect_eq(int'(wake), 0, "R3 wake one cycle");
    ev(1, 9); expect_eq(int'(trap_idx), 'h19, "R4 higher wins");
    ev(1, 3); expect_eq(int'(trap_idx), 'h19, "R4 R7 lower raise no change");
    // R2 re-arbitration on release
    ev(0, 9); expect_eq(int'(trap_idx), 'h15, "R2 drop top");
    expect_eq(int'(wake), 0, "R3 no wake on lower");
    ev(0, 5); expect_eq(int'(trap_idx), 'h13, "R2 next held");
    ev(0, 3); expect_eq(int'(trap_idx), 0, "R8 cleared"); expect_eq(int'(hard_req), 0, "R8 req down");
    // R4 level 0 alone
    ev(1, 0); expect_eq(int'(trap_idx), 0, "R4 level0 idx"); expect_eq(int'(hard_req), 0, "R4 level0 req");
    ev(0, 0);
    // R9 vector load beats event
    vec_load = 1; vec_in = 16'h8001; evt_vld = 1; evt_up = 1; evt_line = 4'd2; cyc(); clr();
    expect_eq(int'(trap_idx), 'h1F, "R9 load wins");
    ev(0, 15); expect_eq(int'(trap_idx), 'h1F, "R9 line2 not held, line0 only keeps idx");
    vload(0); expect_eq(int'(trap_idx), 0, "R8 R9 load empty");
    // R6 R10 non-external index
    cwrite(5); expect_eq(int'(trap_idx), 5, "R10 write"); expect_eq(int'(hard_req), 0, "R10 req kept");
    ev(1, 12); expect_eq(int'(trap_idx), 5, "R6 raise ignored");
    ev(0, 12); expect_eq(int'(trap_idx), 5, "R6 release ignored");
    cwrite(0); ev(1, 7); expect_eq(int'(trap_idx), 'h17, "R1 after clear");
    exc_set = 1; exc_idx = 8'h22; evt_vld = 1; evt_up = 1; evt_line = 4'd8; cyc(); clr();
    expect_eq(int'(trap_idx), 'h22, "R10 write beats arbitration");
    cwrite(0); ev(1, 1); expect_eq(int'(trap_idx), 'h18, "R2 all held rescanned");
    // random stretch against the model
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      evt_vld = r < 70; evt_up = $urandom_range(0, 1) == 1;
      evt_line = 4'($urandom_range(0, 15));
      vec_load = r >= 90 && r < 95; vec_in = 16'($urandom);
      exc_set = r >= 95;
      exc_idx = ($urandom_range(0, 1) == 1) ? 8'h0 : 8'($urandom_range(0, 15) + 16 * $urandom_range(0, 3));
      cyc();
    end
    clr();
    cyc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule